// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers the request lines of many peripherals and hands the processor core one interrupt at a time. Each line is given a two-bit priority through a small synchronous register bus, and a value of zero switches it off. A request that arrives on an enabled line is latched as pending. From the pending set the controller picks the request whose level is strictly above the level the core is running at. It presents that request's vector number, its level and the address of its handler. The handler address is normally the table base plus twice the vector number, since each table entry is two words long. A vector number can also be redirected to a handler address of its own through one of two fast slots.

The core takes the presented request by pulsing an acknowledge. This clears the pending bit and records the level that was taken, and software can read that level back. While reset is asserted, and until the second rising clock edge after reset is released, the controller offers only the reset vector.

Top module: `pvic_top`

## Requirements
- R1: While `rst_n` is low, `in_reset` is 1, `vec_addr` equals RESET_VEC and `int_req` is 0. After release this holds through the first rising edge, and `in_reset` falls at the second rising edge.
- R2: Source i (vector i+2) has a 2-bit field at register address i/8, bits [2*(i%8)+1 : 2*(i%8)]. Fields read back what was written and clear to 0 on reset.
- R3: Only sources in FULL_MASK (by default the sources of vectors 2 and 3) may hold field value 3. Writing 3 to any other source stores 2.
- R4: A pending bit is set at a clock edge where its line is high and its field is nonzero, and it stays set after the line drops. A source whose field is 0 never becomes pending. Pending register 0x10+k bit b shows source 16k+b. Writes to pending addresses are ignored.
- R5: A pending source is presented only when its field value is strictly greater than `core_level`. A source at a level equal to or below `core_level` is not presented.
- R6: Among the presented candidates, the highest field value wins. Ties go to the lowest vector number.
- R7: `int_vector` is the source index plus 2 and `int_level` is the field value. `vec_addr` is VEC_BASE + 2*vector. These outputs appear at the second rising edge after the line is sampled high.
- R8: Fast slot s has its match at address 0x18+3s (bits [6:0]), the upper 5 address bits at 0x19+3s (bits [4:0]) and the lower 16 bits at 0x1A+3s. When the presented vector equals a slot's match, `vec_addr` is that slot's 21-bit address. Slot 0 wins over slot 1.
- R9: `core_ack` while `int_req` is high clears that source's pending bit if its line is low. It drops `int_req` at that edge and stores `int_level` in the level-taken register at 0x1F bits [1:0].
- R10: Addresses that are not mapped read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_SRC | Peripheral request lines, bit i is vector i+2 |
| core_level | input | 2 | Level the core is currently running at |
| core_ack | input | 1 | Core takes the presented request |
| reg_addr | input | 6 | Register bus word address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr, combinational |
| int_req | output | 1 | A request is presented to the core |
| int_vector | output | 7 | Vector number presented |
| int_level | output | 2 | New priority level for the core |
| vec_addr | output | 21 | Handler address, or the reset vector while in_reset |
| in_reset | output | 1 | Reset vector phase is active |

## Verification
A request line sampled high at one rising edge sets its pending bit at that edge. The presented outputs follow at the next edge, so the bench waits two edges before it samples at the falling edge. A change of `core_level` or an acknowledge shows at the outputs after a single edge. The next pending request then appears one edge later. Register reads are combinational and are sampled one time step after the address changes. `in_reset` is checked at the falling edge after the first edge past release and again after the second edge.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
   localparam int ADDR_W      = 6;
   localparam int DATA_W      = 16;
   localparam int LVL_W       = 2;
   localparam int MATCH_W     = 7;
   localparam int FAST_HI_W   = 5;
   localparam int VEC_W       = FAST_HI_W + DATA_W;
   localparam int SRC_PER_REG = DATA_W / LVL_W;
   localparam int PRIO_BASE   = 'h00;
   localparam int PEND_BASE   = 'h10;
   localparam int FAST_BASE   = 'h18;
   localparam int FAST_STRIDE = 3;
   localparam int STAT_ADDR   = 'h1F;
   localparam int HOLD_CYC    = 2;

   typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/pvic_regs.sv
module pvic_regs
   import pvic_pkg::*;
#(
   parameter int                 NUM_SRC   = 80,
   parameter int                 NUM_FAST  = 2,
   parameter logic [NUM_SRC-1:0] FULL_MASK = NUM_SRC'(3)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [ADDR_W-1:0]           reg_addr,
   input  logic                        reg_wr,
   input  logic [DATA_W-1:0]           reg_wdata,
   output logic [DATA_W-1:0]           reg_rdata,
   input  logic [NUM_SRC-1:0]          pend,
   input  logic                        take,
   input  lvl_t                        take_lvl,
   output logic [LVL_W*NUM_SRC-1:0]    prio_flat,
   output logic [MATCH_W*NUM_FAST-1:0] match_flat,
   output logic [VEC_W*NUM_FAST-1:0]   fast_flat,
   output lvl_t                        last_lvl
);
   localparam lvl_t LIMIT_LVL = lvl_t'(2);
   localparam lvl_t TOP_LVL   = lvl_t'(3);

   // one priority field per source; restricted sources clamp on write
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      localparam int REG_IDX = PRIO_BASE + i / SRC_PER_REG;
      localparam int POS     = (i % SRC_PER_REG) * LVL_W;
      lvl_t fld_q;
      lvl_t wr_val;
      if (FULL_MASK[i]) begin : g_full
         assign wr_val = reg_wdata[POS +: LVL_W];
      end else begin : g_lim
         assign wr_val = (reg_wdata[POS +: LVL_W] == TOP_LVL) ? LIMIT_LVL
                                                              : reg_wdata[POS +: LVL_W];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            fld_q <= '0;
         else if (reg_wr && reg_addr == ADDR_W'(REG_IDX))
            fld_q <= wr_val;
      end
      assign prio_flat[i*LVL_W +: LVL_W] = fld_q;
   end

   // fast-interrupt slots: match number plus split 21-bit handler address
   for (genvar s = 0; s < NUM_FAST; s++) begin : g_fast
      localparam int A_MATCH = FAST_BASE + FAST_STRIDE * s;
      logic [MATCH_W-1:0]   match_q;
      logic [FAST_HI_W-1:0] hi_q;
      logic [DATA_W-1:0]    lo_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            match_q <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
         end else if (reg_wr) begin
            if (reg_addr == ADDR_W'(A_MATCH))     match_q <= reg_wdata[MATCH_W-1:0];
            if (reg_addr == ADDR_W'(A_MATCH + 1)) hi_q    <= reg_wdata[FAST_HI_W-1:0];
            if (reg_addr == ADDR_W'(A_MATCH + 2)) lo_q    <= reg_wdata;
         end
      end
      assign match_flat[s*MATCH_W +: MATCH_W] = match_q;
      assign fast_flat[s*VEC_W +: VEC_W]      = {hi_q, lo_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         last_lvl <= '0;
      else if (take)
         last_lvl <= take_lvl;
   end

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (reg_addr == ADDR_W'(PRIO_BASE + i / SRC_PER_REG))
            reg_rdata[(i % SRC_PER_REG) * LVL_W +: LVL_W] = prio_flat[i*LVL_W +: LVL_W];
         if (reg_addr == ADDR_W'(PEND_BASE + i / DATA_W))
            reg_rdata[i % DATA_W] = pend[i];
      end
      for (int s = 0; s < NUM_FAST; s++) begin
         if (reg_addr == ADDR_W'(FAST_BASE + FAST_STRIDE * s))
            reg_rdata[MATCH_W-1:0] = match_flat[s*MATCH_W +: MATCH_W];
         if (reg_addr == ADDR_W'(FAST_BASE + FAST_STRIDE * s + 1))
            reg_rdata[FAST_HI_W-1:0] = fast_flat[s*VEC_W + DATA_W +: FAST_HI_W];
         if (reg_addr == ADDR_W'(FAST_BASE + FAST_STRIDE * s + 2))
            reg_rdata = fast_flat[s*VEC_W +: DATA_W];
      end
      if (reg_addr == ADDR_W'(STAT_ADDR))
         reg_rdata[LVL_W-1:0] = last_lvl;
   end
endmodule

// File: rtl/pvic_pending.sv
module pvic_pending
   import pvic_pkg::*;
#(
   parameter int NUM_SRC = 80,
   parameter int IDX_W   = $clog2(NUM_SRC)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_SRC-1:0]       irq_in,
   input  logic [LVL_W*NUM_SRC-1:0] prio_flat,
   input  logic                     take,
   input  logic [IDX_W-1:0]         take_idx,
   output logic [NUM_SRC-1:0]       pend
);
   logic [NUM_SRC-1:0] armed;
   logic [NUM_SRC-1:0] clr;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_arm
      assign armed[i] = |prio_flat[i*LVL_W +: LVL_W];
   end

   assign clr = take ? (NUM_SRC'(1) << take_idx) : '0;

   // a clear is overridden by a line that is still asserted
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend <= '0;
      else
         pend <= (pend & ~clr) | (irq_in & armed);
   end
endmodule

// File: rtl/pvic_arbiter.sv
module pvic_arbiter
   import pvic_pkg::*;
#(
   parameter int NUM_SRC = 80,
   parameter int IDX_W   = $clog2(NUM_SRC)
) (
   input  logic [NUM_SRC-1:0]       pend,
   input  logic [LVL_W*NUM_SRC-1:0] prio_flat,
   input  lvl_t                     core_level,
   output logic                     found,
   output logic [IDX_W-1:0]         win_idx,
   output lvl_t                     win_lvl
);
   lvl_t cand;

   // descending scan with >= lets the lowest index keep a tie
   always_comb begin
      found   = 1'b0;
      win_idx = '0;
      win_lvl = '0;
      cand    = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         cand = prio_flat[i*LVL_W +: LVL_W];
         if (pend[i] && cand > core_level && (!found || cand >= win_lvl)) begin
            found   = 1'b1;
            win_idx = IDX_W'(i);
            win_lvl = cand;
         end
      end
   end
endmodule

// File: rtl/pvic_vector.sv
module pvic_vector
   import pvic_pkg::*;
#(
   parameter int               NUM_SRC   = 80,
   parameter int               FIRST_VEC = 2,
   parameter int               NUM_FAST  = 2,
   parameter logic [VEC_W-1:0] VEC_BASE  = 21'h010000,
   parameter logic [VEC_W-1:0] RESET_VEC = 21'h000004,
   parameter int               IDX_W     = $clog2(NUM_SRC)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        found,
   input  logic [IDX_W-1:0]            win_idx,
   input  lvl_t                        win_lvl,
   input  logic [MATCH_W*NUM_FAST-1:0] match_flat,
   input  logic [VEC_W*NUM_FAST-1:0]   fast_flat,
   input  logic                        core_ack,
   output logic                        int_req,
   output logic [MATCH_W-1:0]          int_vector,
   output lvl_t                        int_level,
   output logic [VEC_W-1:0]            vec_addr,
   output logic                        in_reset,
   output logic                        take,
   output logic [IDX_W-1:0]            take_idx
);
   localparam int HOLD_W = $clog2(HOLD_CYC + 1);

   logic [HOLD_W-1:0]  hold_q;
   logic [MATCH_W-1:0] win_vec;
   logic [VEC_W-1:0]   next_addr;
   logic               valid_q;
   logic [MATCH_W-1:0] vec_q;
   lvl_t               lvl_q;
   logic [VEC_W-1:0]   addr_q;
   logic [IDX_W-1:0]   idx_q;

   assign win_vec = MATCH_W'(win_idx) + MATCH_W'(FIRST_VEC);

   // lower slot numbers are scanned last so they take precedence
   always_comb begin
      next_addr = VEC_BASE + VEC_W'({win_vec, 1'b0});
      for (int s = NUM_FAST - 1; s >= 0; s--) begin
         if (match_flat[s*MATCH_W +: MATCH_W] == win_vec)
            next_addr = fast_flat[s*VEC_W +: VEC_W];
      end
      if (!found)
         next_addr = '0;
   end

   assign take = core_ack & valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q  <= HOLD_W'(HOLD_CYC);
         valid_q <= 1'b0;
         vec_q   <= '0;
         lvl_q   <= '0;
         addr_q  <= '0;
         idx_q   <= '0;
      end else begin
         if (hold_q != '0)
            hold_q <= hold_q - HOLD_W'(1);
         if (hold_q != '0 || take) begin
            valid_q <= 1'b0;
            vec_q   <= '0;
            lvl_q   <= '0;
            addr_q  <= '0;
            idx_q   <= '0;
         end else begin
            valid_q <= found;
            vec_q   <= found ? win_vec : '0;
            lvl_q   <= found ? win_lvl : '0;
            addr_q  <= next_addr;
            idx_q   <= win_idx;
         end
      end
   end

   assign in_reset   = (hold_q != '0);
   assign int_req    = valid_q;
   assign int_vector = vec_q;
   assign int_level  = lvl_q;
   assign vec_addr   = in_reset ? RESET_VEC : addr_q;
   assign take_idx   = idx_q;
endmodule

// File: rtl/pvic_top.sv
module pvic_top
   import pvic_pkg::*;
#(
   parameter int                 NUM_SRC   = 80,
   parameter int                 FIRST_VEC = 2,
   parameter int                 NUM_FAST  = 2,
   parameter logic [20:0]        VEC_BASE  = 21'h010000,
   parameter logic [20:0]        RESET_VEC = 21'h000004,
   parameter logic [NUM_SRC-1:0] FULL_MASK = NUM_SRC'(3)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_in,
   input  logic [1:0]         core_level,
   input  logic               core_ack,
   input  logic [5:0]         reg_addr,
   input  logic               reg_wr,
   input  logic [15:0]        reg_wdata,
   output logic [15:0]        reg_rdata,
   output logic               int_req,
   output logic [6:0]         int_vector,
   output logic [1:0]         int_level,
   output logic [20:0]        vec_addr,
   output logic               in_reset
);
   localparam int IDX_W     = $clog2(NUM_SRC);
   localparam int PRIO_REGS = (NUM_SRC + SRC_PER_REG - 1) / SRC_PER_REG;
   localparam int PEND_REGS = (NUM_SRC + DATA_W - 1) / DATA_W;

   if (NUM_SRC < 2 || FIRST_VEC + NUM_SRC > (1 << MATCH_W) - 1) begin : g_bad_src
      $error("pvic_top: NUM_SRC/FIRST_VEC do not fit the vector number width");
   end
   if (PRIO_REGS > PEND_BASE - PRIO_BASE) begin : g_bad_prio
      $error("pvic_top: priority registers overrun the pending window");
   end
   if (PEND_REGS > FAST_BASE - PEND_BASE) begin : g_bad_pend
      $error("pvic_top: pending registers overrun the fast-slot window");
   end
   if (NUM_FAST < 1 || FAST_BASE + FAST_STRIDE * NUM_FAST > STAT_ADDR) begin : g_bad_fast
      $error("pvic_top: NUM_FAST out of range");
   end

   logic [LVL_W*NUM_SRC-1:0]    prio_flat;
   logic [MATCH_W*NUM_FAST-1:0] match_flat;
   logic [VEC_W*NUM_FAST-1:0]   fast_flat;
   logic [NUM_SRC-1:0]          pend;
   lvl_t                        last_lvl;
   logic                        found;
   logic [IDX_W-1:0]            win_idx;
   lvl_t                        win_lvl;
   logic                        take;
   logic [IDX_W-1:0]            take_idx;

   pvic_regs #(.NUM_SRC(NUM_SRC), .NUM_FAST(NUM_FAST), .FULL_MASK(FULL_MASK)) regs_i (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pend(pend), .take(take),
      .take_lvl(int_level), .prio_flat(prio_flat), .match_flat(match_flat),
      .fast_flat(fast_flat), .last_lvl(last_lvl)
   );

   pvic_pending #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) pend_i (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .prio_flat(prio_flat),
      .take(take), .take_idx(take_idx), .pend(pend)
   );

   pvic_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) arb_i (
      .pend(pend), .prio_flat(prio_flat), .core_level(core_level),
      .found(found), .win_idx(win_idx), .win_lvl(win_lvl)
   );

   pvic_vector #(.NUM_SRC(NUM_SRC), .FIRST_VEC(FIRST_VEC), .NUM_FAST(NUM_FAST),
                 .VEC_BASE(VEC_BASE), .RESET_VEC(RESET_VEC), .IDX_W(IDX_W)) vec_i (
      .clk(clk), .rst_n(rst_n), .found(found), .win_idx(win_idx), .win_lvl(win_lvl),
      .match_flat(match_flat), .fast_flat(fast_flat), .core_ack(core_ack),
      .int_req(int_req), .int_vector(int_vector), .int_level(int_level),
      .vec_addr(vec_addr), .in_reset(in_reset), .take(take), .take_idx(take_idx)
   );
endmodule

// File: rtl/pvic_chk.sv
module pvic_chk #(
   parameter int          NUM_SRC   = 80,
   parameter int          FIRST_VEC = 2,
   parameter logic [20:0] RESET_VEC = 21'h000004
) (
   input logic        clk,
   input logic        rst_n,
   input logic [1:0]  core_level,
   input logic        core_ack,
   input logic        int_req,
   input logic [6:0]  int_vector,
   input logic [1:0]  int_level,
   input logic [20:0] vec_addr,
   input logic        in_reset,
   input logic [1:0]  last_lvl
);
   assert_reset_vector_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_reset |-> (vec_addr == RESET_VEC && !int_req));

   assert_strictly_higher_R5: assert property (@(posedge clk) disable iff (!rst_n)
      int_req |-> (int_level > $past(core_level)));

   assert_level_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      int_req |-> (int_level != 2'd0));

   assert_vector_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      int_req |-> (int_vector >= 7'(FIRST_VEC) && int_vector < 7'(FIRST_VEC + NUM_SRC)));

   assert_ack_drops_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (core_ack && int_req) |=> !int_req);

   assert_level_captured_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (core_ack && int_req) |=> (last_lvl == $past(int_level)));
endmodule

bind pvic_top pvic_chk #(.NUM_SRC(NUM_SRC), .FIRST_VEC(FIRST_VEC), .RESET_VEC(RESET_VEC)) chk_i (
   .clk(clk), .rst_n(rst_n), .core_level(core_level), .core_ack(core_ack),
   .int_req(int_req), .int_vector(int_vector), .int_level(int_level),
   .vec_addr(vec_addr), .in_reset(in_reset), .last_lvl(last_lvl)
);

// File: tb/pvic_top_tb.sv
module pvic_top_tb_top;
   localparam int          NSRC  = 80;
   localparam logic [20:0] VBASE = 21'h010000;
   localparam logic [20:0] RVEC  = 21'h000004;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NSRC-1:0] irq_in = '0;
   logic [1:0]      core_level = 2'd0;
   logic            core_ack = 1'b0;
   logic [5:0]      reg_addr = '0;
   logic            reg_wr = 1'b0;
   logic [15:0]     reg_wdata = '0;
   logic [15:0]     reg_rdata;
   logic            int_req;
   logic [6:0]      int_vector;
   logic [1:0]      int_level;
   logic [20:0]     vec_addr;
   logic            in_reset;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   pvic_top #(.NUM_SRC(NSRC), .FIRST_VEC(2), .NUM_FAST(2), .VEC_BASE(VBASE),
              .RESET_VEC(RVEC), .FULL_MASK(NSRC'(3))) dut_i (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .core_level(core_level),
      .core_ack(core_ack), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .int_req(int_req),
      .int_vector(int_vector), .int_level(int_level), .vec_addr(vec_addr),
      .in_reset(in_reset)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [5:0] a, input logic [15:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      tick();
      reg_wr = 1'b0;
   endtask

   task automatic rd_check(input string tag, input logic [5:0] a, input logic [15:0] exp);
      reg_addr = a;
      #1;
      check(tag, 32'(reg_rdata), 32'(exp));
   endtask

   task automatic ack();
      core_ack = 1'b1;
      tick();
      core_ack = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      tick();
      check("R1 in_reset during reset", 32'(in_reset), 1);
      check("R1 vec_addr during reset", 32'(vec_addr), 32'(RVEC));
      check("R1 no request during reset", 32'(int_req), 0);
      rst_n = 1'b1;
      tick();
      check("R1 still held after first edge", 32'(in_reset), 1);
      check("R1 reset vector after first edge", 32'(vec_addr), 32'(RVEC));
      tick();
      check("R1 released at second edge", 32'(in_reset), 0);
      rd_check("R2 field reset value", 6'h05, 16'h0000);
      rd_check("R8 match reset value", 6'h18, 16'h0000);
   endtask

   task automatic t_fields();
      wr(6'h04, 16'h2961);
      rd_check("R2 field readback", 6'h04, 16'h2961);
      wr(6'h00, 16'hFFFF);
      rd_check("R3 clamp with full-range sources", 6'h00, 16'hAAAF);
      wr(6'h09, 16'h001B);
      rd_check("R3 clamp on limited source", 6'h09, 16'h001A);
      wr(6'h00, 16'h0000);
      wr(6'h04, 16'h0000);
      wr(6'h09, 16'h0000);
   endtask

   task automatic t_pending();
      wr(6'h02, 16'h0100);            // source 20 at level 1, source 21 off
      irq_in[20] = 1'b1; irq_in[21] = 1'b1;
      tick();
      irq_in[20] = 1'b0; irq_in[21] = 1'b0;
      tick();
      check("R7 request presented", 32'(int_req), 1);
      check("R7 vector number", 32'(int_vector), 22);
      check("R7 level", 32'(int_level), 1);
      check("R7 vector address", 32'(vec_addr), 32'(VBASE + 21'd44));
      rd_check("R4 pending latched, disabled source absent", 6'h11, 16'h0010);
      wr(6'h11, 16'hFFFF);
      rd_check("R4 pending write ignored", 6'h11, 16'h0010);
      ack();
      check("R9 request dropped on ack", 32'(int_req), 0);
      rd_check("R9 pending cleared", 6'h11, 16'h0000);
      rd_check("R9 level taken", 6'h1F, 16'h0001);
   endtask

   task automatic t_preempt();
      core_level = 2'd1;
      wr(6'h03, 16'h2000);            // source 30 at level 2
      irq_in[20] = 1'b1;
      tick(); tick(); tick();
      check("R5 equal level not presented", 32'(int_req), 0);
      irq_in[30] = 1'b1;
      tick(); tick();
      check("R5 higher level presented", 32'(int_req), 1);
      check("R5 higher level vector", 32'(int_vector), 32);
      check("R7 level-2 address", 32'(vec_addr), 32'(VBASE + 21'd64));
      core_level = 2'd2;
      tick();
      check("R5 withdrawn when core level rises", 32'(int_req), 0);
      irq_in[20] = 1'b0; irq_in[30] = 1'b0;
      core_level = 2'd0;
      tick();
      check("R6 higher level beats lower vector", 32'(int_vector), 32);
      ack();
      check("R9 gap after ack", 32'(int_req), 0);
      tick();
      check("R6 next request follows", 32'(int_vector), 22);
      ack();
      rd_check("R9 level of last taken", 6'h1F, 16'h0001);
   endtask

   task automatic t_tie();
      wr(6'h05, 16'h0802);            // sources 40 and 45 at level 2
      irq_in[40] = 1'b1; irq_in[45] = 1'b1;
      tick();
      irq_in[40] = 1'b0; irq_in[45] = 1'b0;
      tick();
      check("R6 tie goes to lower vector", 32'(int_vector), 42);
      ack();
      tick();
      check("R6 tie loser follows", 32'(int_vector), 47);
      ack();
      wr(6'h00, 16'h000C);            // source 1 at top level
      core_level = 2'd2;
      irq_in[1] = 1'b1;
      tick();
      irq_in[1] = 1'b0;
      tick();
      check("R3 top level presented above level 2", 32'(int_level), 3);
      check("R3 top level vector", 32'(int_vector), 3);
      ack();
      rd_check("R9 top level captured", 6'h1F, 16'h0003);
      core_level = 2'd0;
      wr(6'h00, 16'h0000);
   endtask

   task automatic t_fast();
      wr(6'h18, 16'hFFAA);
      rd_check("R8 match bits only", 6'h18, 16'h002A);
      wr(6'h19, 16'hFFF5);
      rd_check("R8 high part bits only", 6'h19, 16'h0015);
      wr(6'h1A, 16'hBEEF);
      wr(6'h1B, 16'd42);
      wr(6'h1C, 16'h0001);
      wr(6'h1D, 16'h1234);
      irq_in[40] = 1'b1;
      tick();
      irq_in[40] = 1'b0;
      tick();
      check("R8 slot 0 wins on double match", 32'(vec_addr), 32'h15BEEF);
      check("R8 vector unchanged", 32'(int_vector), 42);
      ack();
      wr(6'h1B, 16'd47);
      irq_in[45] = 1'b1;
      tick();
      irq_in[45] = 1'b0;
      tick();
      check("R8 slot 1 address", 32'(vec_addr), 32'h011234);
      ack();
   endtask

   task automatic t_unmapped();
      wr(6'h0C, 16'hFFFF);
      rd_check("R10 unmapped reads zero", 6'h0C, 16'h0000);
      rd_check("R10 unused pending register", 6'h15, 16'h0000);
      rd_check("R10 gap before level register", 6'h1E, 16'h0000);
   endtask

   initial begin
      repeat (2) @(negedge clk);
      t_reset();
      t_fields();
      t_pending();
      t_preempt();
      t_tie();
      t_fast();
      t_unmapped();
      t_reset();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule